// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block is the target side of a two-wire serial link that carries voltage-ID commands to a pair of regulator rails. Each command is a single-byte write using the SMBus send-byte transaction: START, an address byte (seven address bits and a direction bit), an acknowledge, one data byte, a second acknowledge, then STOP. The receiver oversamples SCL and SDA with the system clock. It finds START and STOP conditions, shifts in both bytes, and pulls SDA low during the acknowledge bits. It never drives SDA high.

Three address bits choose the rails. One bit points at the core rail and one at the northbridge rail, and a command may select both. A third bit names a second core rail that this receiver does not implement. The data byte carries a 7-bit VID code in its low bits. Its top bit is an active-low light-load hint. The settings are staged and written to the rail registers only when STOP closes an acknowledged command. Each rail that is written emits a one-cycle update strobe, which downstream sequencing logic uses to begin its voltage transition.

Top module: `vid_cmd_rx`

## Requirements
- R1: After reset, both rails hold VID 0 and light-load flag 1, no update strobe is active and SDA is released (`sda_pull_o` = 0).
- R2: The address byte is acknowledged exactly when address bits 6:4 equal 3'b110, the direction bit (last bit on the wire) is 0 for write, and at least one of address bit 1 (core rail) or address bit 0 (northbridge rail) is 1. Address bit 3 has no effect.
- R3: A non-acknowledged address makes the receiver ignore the bus until the next START. The data byte is not acknowledged and no rail changes.
- R4: After an acknowledged address, the 8-bit data byte is acknowledged.
- R5: At STOP following an acknowledged data byte, each selected rail loads VID = data[6:0] and light-load flag = data[7]. Rails that are not selected keep their values.
- R6: Each rail written by a command asserts its update strobe for exactly one clock cycle, once per command. The strobe appears a fixed number of cycles after STOP.
- R7: No rail output or strobe changes between the data acknowledge and STOP.
- R8: A STOP that arrives before the data acknowledge discards the command, and no rail changes.
- R9: A repeated START in the middle of a command discards it and begins a new address phase that is decoded normally.
- R10: An address whose only rail-select bit is bit 2 (the unsupported second core rail) is not acknowledged. Bit 2 set next to a supported select bit has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| core_vid_o | output | 7 | Core rail VID code |
| core_lowload_n_o | output | 1 | Core rail light-load flag, 0 = power-save allowed |
| core_upd_o | output | 1 | Core rail update strobe |
| nb_vid_o | output | 7 | Northbridge rail VID code |
| nb_lowload_n_o | output | 1 | Northbridge rail light-load flag, 0 = power-save allowed |
| nb_upd_o | output | 1 | Northbridge rail update strobe |

## Verification
A frame state that is wrong by one bit shows up within a byte. The acknowledge moves to the wrong SCL pulse, or the latched data is shifted or bit-swapped, and both are visible at the first acknowledge sample or at the rail outputs a few cycles after STOP. A decode error in the address prefix, the direction bit or the select bits shows as an acknowledge that appears or disappears. The bench sweeps every address with both direction values, so it catches such errors. A commit that fires on the wrong event either moves a rail before STOP or changes it after an aborted command, and the bench checks both.

// File: rtl/vid_rx_pkg.sv
package vid_rx_pkg;
  localparam int VID_W       = 7;
  localparam int BYTE_W      = VID_W + 1;
  localparam int NUM_RAILS   = 2;
  localparam int SYNC_STAGES = 2;
  localparam logic [2:0] ADDR_PREFIX = 3'b110;

  // rail index: 0 = core, 1 = northbridge
  localparam int RAIL_CORE = 0;
  localparam int RAIL_NB   = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK_A,
    ST_DATA,
    ST_DATA_END,
    ST_ACK_D,
    ST_WAIT_STOP,
    ST_IGNORE
  } frame_st_e;

  // byte as shifted: {addr[6:0], rw}
  function automatic logic addr_ok(input logic [7:0] b);
    return (b[7:5] == ADDR_PREFIX) && !b[0] && (b[2] || b[1]);
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = vid_rx_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s = scl_sr[STAGES-1];
  assign sda_s = sda_sr[STAGES-1];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import vid_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic              commit_o,
  output logic [NUM_RAILS-1:0] sel_o,
  output logic [BYTE_W-1:0] data_o
);
  frame_st_e         state_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, sh_next;
  logic              ok_q, pull_q, commit_q;
  logic [NUM_RAILS-1:0] sel_q;

  assign sh_next = {sh_q[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ok_q     <= 1'b0;
      sel_q    <= '0;
      pull_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_i) begin
        // repeated START drops anything in flight
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        if (state_q == ST_WAIT_STOP) commit_q <= 1'b1;
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            sh_q  <= sh_next;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              ok_q                <= addr_ok(sh_next);
              sel_q[RAIL_CORE]    <= sh_next[2];
              sel_q[RAIL_NB]      <= sh_next[1];
              state_q             <= ST_ADDR_END;
            end
          end
          ST_ADDR_END: if (scl_fall_i) begin
            if (ok_q) begin
              pull_q  <= 1'b1;
              state_q <= ST_ACK_A;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
          ST_ACK_A: if (scl_fall_i) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: if (scl_rise_i) begin
            sh_q  <= sh_next;
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) state_q <= ST_DATA_END;
          end
          ST_DATA_END: if (scl_fall_i) begin
            pull_q  <= 1'b1;
            state_q <= ST_ACK_D;
          end
          ST_ACK_D: if (scl_fall_i) begin
            pull_q  <= 1'b0;
            state_q <= ST_WAIT_STOP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign commit_o   = commit_q;
  assign sel_o      = sel_q;
  assign data_o     = sh_q;

  // R3
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !pull_q);

  // R2
  pull_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> $past(scl_fall_i));

  // R8
  no_early_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && state_q != ST_WAIT_STOP) |=> !commit_q);
endmodule

// File: rtl/rail_reg.sv
module rail_reg #(
  parameter int VID_W = vid_rx_pkg::VID_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [VID_W:0] data_i,
  output logic [VID_W-1:0] vid_o,
  output logic           lowload_n_o,
  output logic           upd_o
);
  logic [VID_W-1:0] vid_q;
  logic             flag_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_q  <= '0;
      flag_q <= 1'b1;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        vid_q  <= data_i[VID_W-1:0];
        flag_q <= data_i[VID_W];
      end
    end
  end

  assign vid_o       = vid_q;
  assign lowload_n_o = flag_q;
  assign upd_o       = upd_q;

  // R6
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  // R7
  vid_moves_with_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(vid_q) && $stable(flag_q)));
endmodule

// File: rtl/vid_cmd_rx.sv
module vid_cmd_rx
  import vid_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [VID_W-1:0] core_vid_o,
  output logic             core_lowload_n_o,
  output logic             core_upd_o,
  output logic [VID_W-1:0] nb_vid_o,
  output logic             nb_lowload_n_o,
  output logic             nb_upd_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit;
  logic [NUM_RAILS-1:0] sel;
  logic [BYTE_W-1:0]    data;
  logic [VID_W-1:0]     vid   [NUM_RAILS];
  logic [NUM_RAILS-1:0] flag_n, upd;

  line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  frame_fsm i_fsm (
    .clk_i, .rst_ni,
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_pull_o (sda_pull_o),
    .commit_o   (commit),
    .sel_o      (sel),
    .data_o     (data)
  );

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    rail_reg #(.VID_W(VID_W)) i_rail (
      .clk_i, .rst_ni,
      .load_i      (commit && sel[r]),
      .data_i      (data),
      .vid_o       (vid[r]),
      .lowload_n_o (flag_n[r]),
      .upd_o       (upd[r])
    );
  end

  assign core_vid_o       = vid[RAIL_CORE];
  assign core_lowload_n_o = flag_n[RAIL_CORE];
  assign core_upd_o       = upd[RAIL_CORE];
  assign nb_vid_o         = vid[RAIL_NB];
  assign nb_lowload_n_o   = flag_n[RAIL_NB];
  assign nb_upd_o         = upd[RAIL_NB];

  // R5
  upd_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd) |-> $past(stop_det, 2));

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> !sda_pull_o);
endmodule

// File: tb/test_vid_cmd_rx.sv
module test_vid_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4; // quarter bit time in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [6:0] core_vid, nb_vid;
  logic core_ll, nb_ll, core_upd, nb_upd;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_cmd_rx i_vid_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull),
    .core_vid_o(core_vid), .core_lowload_n_o(core_ll), .core_upd_o(core_upd),
    .nb_vid_o(nb_vid), .nb_lowload_n_o(nb_ll), .nb_upd_o(nb_upd)
  );

  int n_run = 0, n_fail = 0;
  int core_cnt = 0, nb_cnt = 0;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (core_upd) core_cnt <= core_cnt + 1;
    if (nb_upd)   nb_cnt   <= nb_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(2*Q);
    sda_m = 1'b0; wclk(2*Q);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic bus_stop;
    wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl = 1'b1;   wclk(2*Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic put_bit(input logic b);
    wclk(Q);
    sda_m = b;  wclk(Q);
    scl = 1'b1; wclk(2*Q);
    scl = 1'b0;
  endtask

  task automatic get_ack(output logic ack);
    wclk(Q);
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(Q);
    ack = ~sda_line;
    wclk(Q);
    scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask

  logic [6:0] e_core_vid = '0, e_nb_vid = '0;
  logic       e_core_ll = 1'b1, e_nb_ll = 1'b1;

  task automatic chk_rails(input string req);
    chk(core_vid == e_core_vid, req, core_vid, e_core_vid);
    chk(core_ll  == e_core_ll,  req, core_ll,  e_core_ll);
    chk(nb_vid   == e_nb_vid,   req, nb_vid,   e_nb_vid);
    chk(nb_ll    == e_nb_ll,    req, nb_ll,    e_nb_ll);
  endtask

  initial begin
    int c0, n0;
    logic aa, ad;
    logic [7:0] d;
    logic exp_ok;
    wclk(3);
    // R1 reset state
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
    chk(core_upd == 1'b0 && nb_upd == 1'b0, "R1", {core_upd, nb_upd}, 0);
    chk_rails("R1");
    rst_n = 1'b1;
    wclk(5);

    // address sweep, both directions (R2 R3 R4 R5 R6 R7 R10)
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        d = 8'((a * 37 + rw * 91 + 11) & 255);
        exp_ok = (a[6:4] == 3'b110) && (rw == 0) && (a[1] || a[0]);
        c0 = core_cnt; n0 = nb_cnt;
        bus_start;
        put_byte({7'(a), 1'(rw)}, aa);
        chk(aa == exp_ok, (a[2] && !a[1] && !a[0]) ? "R10" : "R2", aa, exp_ok);
        put_byte(d, ad);
        chk(ad == exp_ok, exp_ok ? "R4" : "R3", ad, exp_ok);
        wclk(2*Q);
        // R7 nothing moves before STOP
        chk(core_cnt == c0 && nb_cnt == n0, "R7", core_cnt + nb_cnt, c0 + n0);
        chk_rails("R7");
        bus_stop;
        wclk(12);
        if (exp_ok && a[1]) begin e_core_vid = d[6:0]; e_core_ll = d[7]; end
        if (exp_ok && a[0]) begin e_nb_vid   = d[6:0]; e_nb_ll   = d[7]; end
        chk_rails(exp_ok ? "R5" : "R3");
        chk(core_cnt - c0 == int'(exp_ok && a[1]), "R6", core_cnt - c0, int'(exp_ok && a[1]));
        chk(nb_cnt - n0   == int'(exp_ok && a[0]), "R6", nb_cnt - n0,   int'(exp_ok && a[0]));
      end
    end

    // R8 STOP after address ack, and STOP mid data byte
    c0 = core_cnt; n0 = nb_cnt;
    bus_start;
    put_byte({7'h63, 1'b0}, aa);
    chk(aa == 1'b1, "R8", aa, 1);
    bus_stop;
    wclk(12);
    bus_start;
    put_byte({7'h6B, 1'b0}, aa);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_stop;
    wclk(12);
    chk(core_cnt == c0 && nb_cnt == n0, "R8", core_cnt + nb_cnt, c0 + n0);
    chk_rails("R8");

    // R9 repeated START mid data, then new command to northbridge only
    bus_start;
    put_byte({7'h63, 1'b0}, aa);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start;
    put_byte({7'h61, 1'b0}, aa);
    chk(aa == 1'b1, "R9", aa, 1);
    put_byte(8'h2A, ad);
    chk(ad == 1'b1, "R9", ad, 1);
    bus_stop;
    wclk(12);
    e_nb_vid = 7'h2A; e_nb_ll = 1'b0;
    chk_rails("R9");
    chk(core_cnt == c0 && nb_cnt == n0 + 1, "R9", nb_cnt - n0, 1);

    // R10 bit 2 beside core select is harmless
    bus_start;
    put_byte({7'h66, 1'b0}, aa);
    chk(aa == 1'b1, "R10", aa, 1);
    put_byte(8'h95, ad);
    bus_stop;
    wclk(12);
    e_core_vid = 7'h15; e_core_ll = 1'b1;
    chk_rails("R10");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule